// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches four external interrupt pins and turns their activity into interrupt requests for a CPU core. Every pin has its own two-bit sense code that picks low-level, falling-edge or rising-edge detection; one code value is reserved and silences the pin. In the edge modes a detected edge latches a sticky flag. The flag is cleared when the core acknowledges that pin's interrupt, or when software writes a one to the flag bit. In level mode the flag is held at zero, and the request follows the synchronised pin for as long as it stays low.

Each pin passes through a two-flop synchroniser and one further register, so edges are found by comparing two registered samples. Detection looks only at the pin level and ignores who drives the pin. Software can therefore raise an interrupt by driving the pin as an output. A pending source only requests service when its mask bit and the global enable input are both set. Among unmasked pending sources the lowest pin index wins, and it is reported as a valid strobe with a two-bit index. A small register bus gives access to a flag register, a control register and a mask register.

Top module: `ext_pin_irq`

## Requirements
- R1: The control register (address 1) holds one two-bit sense code per pin, with pin n in bits 2n+1:2n. Code 00 selects low level, 10 selects falling edge and 11 selects rising edge. The register resets to 0x00.
- R2: A pin change is registered by two synchroniser flops, and edges are found by comparing the synchroniser output with one more registered sample. A level held for two or more clock cycles is always detected. An edge sets its flag on the third rising clock edge after the change.
- R3: In an edge mode, a matching edge sets the pin's flag, and the flag stays set until it is cleared. An edge of the opposite direction does not set the flag.
- R4: The flag register is at address 0, with pin n's flag in bit n+4. Writing 1 to a flag bit clears it and writing 0 has no effect. If a clear and a new edge land in the same cycle, the flag ends up set.
- R5: While a pin is in level mode its flag reads 0, and this includes a flag that was set before the mode changed. The pin is pending for as long as its synchronised value is low.
- R6: A pending pin raises a request only when its mask bit (address 2, bit n+4) and the global enable input are both 1. The mask register resets to zero.
- R7: Flag register bits 3:0 and mask register bits 3:0 always read 0, and so does address 3.
- R8: When ack_i is 1, the flag of the pin selected by ack_idx_i is cleared.
- R9: When several unmasked requests are pending, irq_valid_o is 1 and irq_idx_o gives the lowest pin index among them.
- R10: A pin whose sense code is the reserved value 01 never raises a request, and its flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | External interrupt pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable from the core |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 flags, 1 control, 2 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ack_i | input | 1 | Core acknowledges a served interrupt |
| ack_idx_i | input | 2 | Index of the pin being acknowledged |
| irq_valid_o | output | 1 | An unmasked request is pending |
| irq_idx_o | output | 2 | Index of the winning pin |

## Verification
The assertions assume that the bus write strobe and the acknowledge are synchronous to clk and held stable around the rising edge. They also assume that ack_idx_i is meaningful only while ack_i is high. The pins may be fully asynchronous, because the assertions only look at the registered samples. The bench drives every input on the falling edge and samples outputs on the falling edge. It holds each pin level for at least two cycles, which keeps pin activity inside the window where detection is guaranteed. It only creates the write-and-edge collision at the one edge where it was computed to occur.

// File: rtl/ext_pin_irq.sv
module ext_pin_irq #(
  parameter int NPINS = 4,
  parameter int DW    = 8,
  localparam int IW   = $clog2(NPINS),
  localparam int FLO  = DW - NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             gie_i,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             ack_i,
  input  logic [IW-1:0]    ack_idx_i,
  output logic             irq_valid_o,
  output logic [IW-1:0]    irq_idx_o
);

  logic [NPINS-1:0]   s1, s2, s3;
  logic [NPINS-1:0]   flag, flag_nxt, mask, pend, req;
  logic [2*NPINS-1:0] ctrl;

  wire wr_flag = bus_we && bus_addr == 2'd0;
  wire wr_ctrl = bus_we && bus_addr == 2'd1;
  wire wr_mask = bus_we && bus_addr == 2'd2;

  wire [NPINS-1:0] fall = s3 & ~s2;
  wire [NPINS-1:0] rise = ~s3 & s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
      flag <= '0;
      ctrl <= '0;
      mask <= '0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      s3 <= s2;
      flag <= flag_nxt;
      if (wr_ctrl) ctrl <= bus_wdata[2*NPINS-1:0];
      if (wr_mask) mask <= bus_wdata[DW-1:FLO];
    end

  always_comb
    for (int i = 0; i < NPINS; i++) begin
      logic [1:0] m;
      logic hit, clr;
      m   = ctrl[2*i +: 2];
      hit = (m == 2'b10 && fall[i]) || (m == 2'b11 && rise[i]);
      clr = (wr_flag && bus_wdata[FLO+i]) || (ack_i && ack_idx_i == IW'(i));
      if (!m[1])    flag_nxt[i] = 1'b0;
      else if (hit) flag_nxt[i] = 1'b1;
      else if (clr) flag_nxt[i] = 1'b0;
      else          flag_nxt[i] = flag[i];
      pend[i] = (m == 2'b00) ? ~s2[i] : (m[1] & flag[i]);
    end

  assign req = pend & mask & {NPINS{gie_i}};
  assign irq_valid_o = |req;

  always_comb begin
    irq_idx_o = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (req[i]) irq_idx_o = IW'(i);
  end

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = {flag, {FLO{1'b0}}};
      2'd1:    bus_rdata = DW'(ctrl);
      2'd2:    bus_rdata = {mask, {FLO{1'b0}}};
      default: bus_rdata = '0;
    endcase

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[2*g+1] && $past(!ctrl[2*g+1])) |-> !flag[g]); // R5
    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[2*g +: 2] == 2'b11 && !s3[g] && s2[g]) |=> flag[g]); // R3
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[2*g +: 2] == 2'b01) |-> !req[g]); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_idx_i == IW'(g) && !wr_ctrl && !(ctrl[2*g+1] && (fall[g] || rise[g])))
      |=> !flag[g]); // R8
  end

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (gie_i && mask[irq_idx_o])); // R6
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ((req & ((NPINS'(1) << irq_idx_o) - NPINS'(1))) == '0)); // R9
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 2'd1) |-> (bus_rdata[FLO-1:0] == '0)); // R7

endmodule

// File: tb/tb_ext_pin_irq.sv
module tb_ext_pin_irq;
  localparam time PERIOD = 10;

  logic       clk = 0, rst_n = 0, gie = 0, we = 0, ack = 0;
  logic [3:0] pin = 4'hF;
  logic [1:0] addr = 0, ack_idx = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irqv;
  logic [1:0] irqi;
  int n_chk = 0, n_ok = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  ext_pin_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .gie_i(gie),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .ack_i(ack), .ack_idx_i(ack_idx), .irq_valid_o(irqv), .irq_idx_o(irqi));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (ok) n_ok++;
    else $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(input logic [1:0] i);
    @(negedge clk); ack = 1; ack_idx = i;
    @(negedge clk); ack = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk(d == 0, "R4", d, 0);
    rd(1, d); chk(d == 0, "R1", d, 0);
    rd(2, d); chk(d == 0, "R6", d, 0);
    chk(irqv == 0, "R6", irqv, 0);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(1, 8'h00); wr(2, 8'h10); gie = 1;
    wait_n(4); chk(irqv == 0, "R5", irqv, 0);
    @(negedge clk); pin[0] = 0;
    @(negedge clk); chk(irqv == 0, "R2", irqv, 0);
    @(negedge clk); chk(irqv && irqi == 0, "R5", {irqv, irqi}, 3'b100);
    rd(0, d); chk(d == 0, "R5", d, 0);
    pin[0] = 1; wait_n(3); chk(irqv == 0, "R5", irqv, 0);
  endtask

  task automatic t_fall;
    logic [7:0] d;
    wr(1, 8'h08); wr(2, 8'h20);
    @(negedge clk); pin[1] = 0;
    wait_n(2); pin[1] = 1;
    wait_n(4);
    rd(0, d); chk(d == 8'h20, "R3", d, 8'h20);
    chk(irqv && irqi == 1, "R2", {irqv, irqi}, 3'b101);
    wait_n(5); rd(0, d); chk(d == 8'h20, "R3", d, 8'h20);
    wr(0, 8'h00); rd(0, d); chk(d == 8'h20, "R4", d, 8'h20);
    wr(0, 8'h20); rd(0, d); chk(d == 8'h00, "R4", d, 0);
    chk(irqv == 0, "R4", irqv, 0);
  endtask

  task automatic t_rise_ack;
    logic [7:0] d;
    wr(1, 8'h30); wr(2, 8'h40);
    @(negedge clk); pin[2] = 0; wait_n(4);
    rd(0, d); chk(d == 0, "R3", d, 0);
    pin[2] = 1; wait_n(4);
    rd(0, d); chk(d == 8'h40, "R1", d, 8'h40);
    chk(irqv && irqi == 2, "R3", {irqv, irqi}, 3'b110);
    do_ack(1); rd(0, d); chk(d == 8'h40, "R8", d, 8'h40);
    do_ack(2); rd(0, d); chk(d == 0, "R8", d, 0);
  endtask

  task automatic t_mask_gie;
    logic [7:0] d;
    wr(1, 8'h30); wr(2, 8'h00);
    @(negedge clk); pin[2] = 0; wait_n(3); pin[2] = 1; wait_n(4);
    rd(0, d); chk(d == 8'h40, "R6", d, 8'h40);
    chk(irqv == 0, "R6", irqv, 0);
    wr(2, 8'h40); gie = 0; #1; chk(irqv == 0, "R6", irqv, 0);
    gie = 1; #1; chk(irqv == 1, "R6", irqv, 1);
    wr(0, 8'h40);
  endtask

  task automatic t_prio;
    wr(1, 8'h88); wr(2, 8'hF0);
    @(negedge clk); pin[1] = 0; pin[3] = 0; wait_n(3); pin[1] = 1; pin[3] = 1; wait_n(4);
    chk(irqv && irqi == 1, "R9", {irqv, irqi}, 3'b101);
    do_ack(1); #1; chk(irqv && irqi == 3, "R9", {irqv, irqi}, 3'b111);
    do_ack(3); #1; chk(irqv == 0, "R8", irqv, 0);
  endtask

  task automatic t_rsvd_level_switch;
    logic [7:0] d;
    wr(1, 8'h40); wr(2, 8'h80);
    @(negedge clk); pin[3] = 0; wait_n(4);
    chk(irqv == 0, "R10", irqv, 0);
    pin[3] = 1; wait_n(4);
    rd(0, d); chk(d == 0, "R10", d, 0);
    wr(1, 8'hC0);
    @(negedge clk); pin[3] = 0; wait_n(3); pin[3] = 1; wait_n(4);
    rd(0, d); chk(d == 8'h80, "R3", d, 8'h80);
    wr(1, 8'h00); wait_n(2);
    rd(0, d); chk(d == 0, "R5", d, 0);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    wr(2, 8'h00); wr(1, 8'h30);
    @(negedge clk); pin[2] = 0; wait_n(4);
    @(negedge clk); pin[2] = 1;
    @(negedge clk);
    @(negedge clk); we = 1; addr = 0; wdata = 8'h40;
    @(negedge clk); we = 0;
    rd(0, d); chk(d == 8'h40, "R4", d, 8'h40);
    wr(0, 8'h40);
  endtask

  task automatic t_low_bits;
    logic [7:0] d;
    wr(2, 8'hFF); rd(2, d); chk(d == 8'hF0, "R7", d, 8'hF0);
    wr(0, 8'h0F); rd(0, d); chk(d[3:0] == 0, "R7", d, 0);
    wr(3, 8'hFF); rd(3, d); chk(d == 0, "R7", d, 0);
    wr(2, 8'h00);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_ok, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 2); t_reset;
    @(negedge clk); rst_n = 1;
    wait_n(3);
    t_level;
    t_fall;
    t_rise_ack;
    t_mask_gie;
    t_prio;
    t_rsvd_level_switch;
    t_set_wins;
    t_low_bits;
    done = 1;
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule